// File: doc/BRIEF.md
# Parallel Port Byte FIFO with Direction-Dependent Service Thresholds

This block is the byte buffer that sits between the host side and the cable side of an enhanced parallel port. In the forward direction the host writes bytes and the peripheral side drains them. In the reverse direction the peripheral side fills the buffer and the host reads it. A 3-bit mode input chooses whether the buffer is held clear, active with an extra holding slot, active without it, or frozen. A registered service request tells the host when a transfer burst is worth servicing.

The usable capacity depends on the mode. The two transfer modes add one holding slot to the 16-entry array, which gives 17 bytes. The test mode uses the bare array, which gives 16. The service threshold has two settings, and the forward and reverse directions use different trip points. The threshold setting can only be captured while the port is in one of the two clearing modes. A host write to a full buffer, or a host read from an empty buffer, raises a sticky error flag. Only the clearing modes and the hard reset remove that flag.

Top module: `pp_fifo`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `empty_o`=1, `full_o`=0, `err_o`=0 and `svc_req_o`=0.
- R2: Bytes leave in the order they were accepted. `rdata_o` always presents the oldest stored byte, and a pop exposes the next byte in the cycle after the pop edge.
- R3: In modes 3'b010 and 3'b011 the capacity is 17. `full_o` stays 0 after 16 accepted pushes and becomes 1 after the 17th.
- R4: In mode 3'b110 the capacity is 16. `full_o` becomes 1 after the 16th accepted push.
- R5: A host write (`host_wr_i`) in the forward direction while the buffer is full is dropped. It sets `err_o`, which stays set, and the stored bytes are unchanged.
- R6: A host read (`host_rd_i`) in the reverse direction while the buffer is empty sets `err_o`.
- R7: In modes 3'b000 and 3'b001 the buffer is emptied and `err_o` is cleared. Both take effect at the next clock edge.
- R8: `thr_sel_i` is captured only at edges where the mode is 3'b000 or 3'b001. Changes of `thr_sel_i` in any other mode have no effect on `svc_req_o`.
- R9: In the forward direction (`dir_i`=0) `svc_req_o` is 1 when the free space (capacity minus stored count) is at least the forward threshold. That threshold is 1 byte when the captured select is 0 and 8 bytes when it is 1.
- R10: In the reverse direction (`dir_i`=1) `svc_req_o` is 1 when the stored count is at least the reverse threshold. That threshold is 15 bytes when the captured select is 0 and 8 bytes when it is 1.
- R11: `full_o`, `empty_o` and `svc_req_o` are registered. Each reflects the count and mode that result from a clock edge, starting right after that edge.
- R12: Direction routes the strobes. With `dir_i`=0 the host writes and the peripheral pops. With `dir_i`=1 the peripheral pushes and the host reads. Strobes from the other side are ignored. In modes 3'b100, 3'b101 and 3'b111 all strobes are ignored and the contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| mode_i | input | 3 | Port mode |
| dir_i | input | 1 | 0 forward (host to cable), 1 reverse |
| thr_sel_i | input | 1 | Threshold select, captured in modes 000/001 |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read strobe |
| per_push_i | input | 1 | Peripheral push strobe |
| per_wdata_i | input | 8 | Peripheral push byte |
| per_pop_i | input | 1 | Peripheral pop strobe |
| rdata_o | output | 8 | Oldest stored byte |
| full_o | output | 1 | Buffer at capacity |
| empty_o | output | 1 | Buffer holds no byte |
| svc_req_o | output | 1 | Service request to the host |
| err_o | output | 1 | Sticky overflow/underflow error |

## Verification
The bench fills the buffer to the 16/17 boundary in both the holding and the bare modes. A design that ignored the holding slot would flag full one byte early, and one that kept it in test mode would flag full one byte late. It writes into a full buffer and then drains all 17 bytes, checking their order. A corrupting overflow shows up as a wrong or shifted byte, and a non-sticky error flag reads 0 afterwards. It probes the service request exactly one byte on each side of every threshold, both forward and reverse. It also toggles the threshold select inside an active mode, so a latch that was not gated would trip reverse service at 8 bytes instead of 15. Finally it checks that wrong-side strobes and strobes in frozen modes leave the buffer empty.

// File: rtl/pp_fifo_pkg.sv
package pp_fifo_pkg;

  typedef enum logic [2:0] {
    M_STD   = 3'b000,
    M_BIDIR = 3'b001,
    M_FIFO  = 3'b010,
    M_XFER  = 3'b011,
    M_RSV4  = 3'b100,
    M_RSV5  = 3'b101,
    M_TEST  = 3'b110,
    M_CFG   = 3'b111
  } pp_mode_e;

  typedef struct packed {
    logic clear;    // buffer and error held clear, threshold open
    logic active;   // strobes honoured
    logic hold_en;  // holding slot adds one byte of capacity
  } mode_ctl_t;

  function automatic mode_ctl_t decode_mode(input logic [2:0] m);
    mode_ctl_t c;
    c.clear   = (m == M_STD)  || (m == M_BIDIR);
    c.active  = (m == M_FIFO) || (m == M_XFER) || (m == M_TEST);
    c.hold_en = (m == M_FIFO) || (m == M_XFER);
    return c;
  endfunction

endpackage

// File: rtl/pp_fifo_ctrl.sv
module pp_fifo_ctrl
  import pp_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SLOTS = DEPTH + 1,
  localparam int unsigned CW = $clog2(SLOTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          thr_sel_i,
  input  logic          over_i,
  input  logic          under_i,
  output mode_ctl_t     ctl_o,
  output logic [CW-1:0] cap_o,
  output logic          thr_q_o,
  output logic          err_o
);

  logic thr_q, err_q;

  always_comb begin
    ctl_o = decode_mode(mode_i);
    cap_o = ctl_o.hold_en ? CW'(SLOTS) : CW'(DEPTH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (ctl_o.clear) thr_q <= thr_sel_i;
      if (ctl_o.clear)                err_q <= 1'b0;
      else if (over_i || under_i)     err_q <= 1'b1;
    end
  end

  assign thr_q_o = thr_q;
  assign err_o   = err_q;

  p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !ctl_o.clear) |=> err_q);

  p_err_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.clear |=> !err_q);

endmodule

// File: rtl/pp_fifo_store.sv
module pp_fifo_store #(
  parameter int unsigned DW = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SLOTS = DEPTH + 1,
  localparam int unsigned CW = $clog2(SLOTS + 1),
  localparam int unsigned PW = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] cap_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_d_o,
  output logic          room_o,
  output logic          have_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] mem_q [SLOTS];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_acc, pop_acc;
  logic          full_q, empty_q;

  function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
    return (p == PW'(SLOTS - 1)) ? '0 : p + PW'(1);
  endfunction

  assign room_o   = cnt_q < cap_i;
  assign have_o   = cnt_q != '0;
  assign push_acc = push_i && room_o && !clear_i;
  assign pop_acc  = pop_i && have_o && !clear_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                    cnt_d = '0;
    else if (push_acc && !pop_acc)  cnt_d = cnt_q + CW'(1);
    else if (pop_acc && !push_acc)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (clear_i) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (push_acc) wp_q <= inc_ptr(wp_q);
        if (pop_acc)  rp_q <= inc_ptr(rp_q);
      end
      cnt_q   <= cnt_d;
      full_q  <= cnt_d >= cap_i;
      empty_q <= cnt_d == '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(SLOTS); i++) mem_q[i] <= '0;
    end else if (push_acc) begin
      mem_q[wp_q] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign cnt_d_o = cnt_d;
  assign full_o  = full_q;
  assign empty_o = empty_q;

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(SLOTS));

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CW'(1)
                  || cnt_q == $past(cnt_q) - CW'(1)));

  p_flag_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_q && empty_q));

endmodule

// File: rtl/pp_fifo_svc.sv
module pp_fifo_svc #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned THR_LO = 1,
  parameter int unsigned THR_MID = 8,
  parameter int unsigned THR_HI = 15,
  localparam int unsigned SLOTS = DEPTH + 1,
  localparam int unsigned CW = $clog2(SLOTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          dir_i,
  input  logic          thr_q_i,
  input  logic [CW-1:0] cnt_d_i,
  input  logic [CW-1:0] cap_i,
  output logic          svc_o
);

  logic [CW-1:0] thr_fwd, thr_rev, free_d;
  logic          svc_d, svc_q;

  always_comb begin
    thr_fwd = thr_q_i ? CW'(THR_MID) : CW'(THR_LO);
    thr_rev = thr_q_i ? CW'(THR_MID) : CW'(THR_HI);
    free_d  = (cnt_d_i >= cap_i) ? '0 : cap_i - cnt_d_i;
    if (!active_i)  svc_d = 1'b0;
    else if (dir_i) svc_d = cnt_d_i >= thr_rev;
    else            svc_d = free_d >= thr_fwd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_q <= 1'b0;
    else         svc_q <= svc_d;
  end

  assign svc_o = svc_q;

  p_svc_empty_fwd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !dir_i && cnt_d_i == '0) |=> svc_q);

  p_svc_empty_rev_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i && cnt_d_i == '0) |=> !svc_q);

endmodule

// File: rtl/pp_fifo.sv
module pp_fifo
  import pp_fifo_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned THR_LO = 1,
  parameter int unsigned THR_MID = 8,
  parameter int unsigned THR_HI = DEPTH - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          dir_i,
  input  logic          thr_sel_i,
  input  logic          host_wr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  input  logic          per_push_i,
  input  logic [DW-1:0] per_wdata_i,
  input  logic          per_pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          svc_req_o,
  output logic          err_o
);

  localparam int unsigned SLOTS = DEPTH + 1;
  localparam int unsigned CW = $clog2(SLOTS + 1);

  mode_ctl_t     ctl;
  logic [CW-1:0] cap, cnt_d;
  logic          thr_q, room, have;
  logic          push, pop, over, under;
  logic [DW-1:0] wdata;

  // forward: host fills, cable drains; reverse: cable fills, host drains
  always_comb begin
    push  = ctl.active && (dir_i ? per_push_i : host_wr_i);
    pop   = ctl.active && (dir_i ? host_rd_i : per_pop_i);
    wdata = dir_i ? per_wdata_i : host_wdata_i;
    over  = ctl.active && !dir_i && host_wr_i && !room;
    under = ctl.active && dir_i && host_rd_i && !have;
  end

  pp_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .thr_sel_i(thr_sel_i),
    .over_i   (over),
    .under_i  (under),
    .ctl_o    (ctl),
    .cap_o    (cap),
    .thr_q_o  (thr_q),
    .err_o    (err_o)
  );

  pp_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(ctl.clear),
    .push_i (push),
    .pop_i  (pop),
    .wdata_i(wdata),
    .cap_i  (cap),
    .rdata_o(rdata_o),
    .cnt_d_o(cnt_d),
    .room_o (room),
    .have_o (have),
    .full_o (full_o),
    .empty_o(empty_o)
  );

  pp_fifo_svc #(
    .DEPTH(DEPTH), .THR_LO(THR_LO), .THR_MID(THR_MID), .THR_HI(THR_HI)
  ) u_svc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(ctl.active),
    .dir_i   (dir_i),
    .thr_q_i (thr_q),
    .cnt_d_i (cnt_d),
    .cap_i   (cap),
    .svc_o   (svc_req_o)
  );

  p_clear_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.clear |=> (empty_o && !full_o && !err_o));

  p_frozen_keep_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl.active && !ctl.clear) |=> $stable(empty_o));

endmodule

// File: tb/tb_pp_fifo.sv
module tb_pp_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       dir = 1'b0, thr_sel = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, per_push = 1'b0, per_pop = 1'b0;
  logic [7:0] host_wdata = '0, per_wdata = '0;
  logic [7:0] rdata;
  logic       full, empty, svc, err;
  int         n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  pp_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dir_i(dir), .thr_sel_i(thr_sel),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata), .host_rd_i(host_rd),
    .per_push_i(per_push), .per_wdata_i(per_wdata), .per_pop_i(per_pop),
    .rdata_o(rdata), .full_o(full), .empty_o(empty), .svc_req_o(svc), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk) mode = m;
    @(negedge clk);
  endtask

  task automatic h_wr(input logic [7:0] d);
    @(negedge clk) begin host_wr = 1'b1; host_wdata = d; end
    @(negedge clk) host_wr = 1'b0;
  endtask

  task automatic h_rd();
    @(negedge clk) host_rd = 1'b1;
    @(negedge clk) host_rd = 1'b0;
  endtask

  task automatic p_push(input logic [7:0] d);
    @(negedge clk) begin per_push = 1'b1; per_wdata = d; end
    @(negedge clk) per_push = 1'b0;
  endtask

  task automatic p_pop();
    @(negedge clk) per_pop = 1'b1;
    @(negedge clk) per_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 err", err, 0);
    chk("R1 svc", svc, 0);
  endtask

  task automatic t_cap17_order();
    dir = 1'b0;
    set_mode(3'b010);
    for (int i = 0; i < 16; i++) h_wr(8'h40 + 8'(i));
    chk("R3 not full at 16", full, 0);
    h_wr(8'h50);
    chk("R3 full at 17", full, 1);
    chk("R9 no svc when full", svc, 0);
    h_wr(8'hEE);
    chk("R5 overflow err", err, 1);
    chk("R5 still full", full, 1);
    for (int i = 0; i < 17; i++) begin
      chk("R2 order", rdata, 8'h40 + i);
      p_pop();
    end
    chk("R2 empty after drain", empty, 1);
    chk("R5 err sticky", err, 1);
    p_push(8'h11);
    chk("R12 wrong-side push ignored", empty, 1);
  endtask

  task automatic t_test16();
    set_mode(3'b000);
    chk("R7 err cleared", err, 0);
    chk("R7 empty", empty, 1);
    set_mode(3'b110);
    for (int i = 0; i < 15; i++) h_wr(8'(i));
    chk("R4 not full at 15", full, 0);
    h_wr(8'h0F);
    chk("R4 full at 16", full, 1);
    set_mode(3'b001);
    chk("R7 cleared by 001", empty, 1);
    chk("R7 full dropped", full, 0);
  endtask

  task automatic t_reverse();
    thr_sel = 1'b0;
    set_mode(3'b000);
    @(negedge clk) begin dir = 1'b1; mode = 3'b011; end
    @(negedge clk) thr_sel = 1'b1;
    h_wr(8'h99);
    chk("R12 host write in reverse ignored", empty, 1);
    for (int i = 0; i < 8; i++) p_push(8'h80 + 8'(i));
    chk("R8 select change locked out", svc, 0);
    for (int i = 8; i < 14; i++) p_push(8'h80 + 8'(i));
    chk("R10 no svc at 14", svc, 0);
    p_push(8'h8E);
    chk("R10 svc at 15", svc, 1);
    chk("R2 reverse head", rdata, 8'h80);
    h_rd();
    chk("R10 svc drops at 14", svc, 0);
    chk("R2 reverse next", rdata, 8'h81);
    set_mode(3'b000);
    set_mode(3'b011);
    for (int i = 0; i < 7; i++) p_push(8'(i));
    chk("R10 mid no svc at 7", svc, 0);
    p_push(8'h07);
    chk("R10 mid svc at 8", svc, 1);
    for (int i = 0; i < 8; i++) h_rd();
    chk("R6 no err before underflow", err, 0);
    h_rd();
    chk("R6 underflow err", err, 1);
  endtask

  task automatic t_forward_svc();
    thr_sel = 1'b1;
    set_mode(3'b000);
    @(negedge clk) begin dir = 1'b0; mode = 3'b011; end
    @(negedge clk);
    chk("R9 mid svc when empty", svc, 1);
    for (int i = 0; i < 9; i++) h_wr(8'(i));
    chk("R9 mid svc free 8", svc, 1);
    h_wr(8'h09);
    chk("R9 mid no svc free 7", svc, 0);
    thr_sel = 1'b0;
    set_mode(3'b000);
    set_mode(3'b010);
    for (int i = 0; i < 16; i++) h_wr(8'(i));
    chk("R9 low svc free 1", svc, 1);
    h_wr(8'h10);
    chk("R9 low no svc free 0", svc, 0);
  endtask

  task automatic t_frozen();
    set_mode(3'b000);
    set_mode(3'b100);
    h_wr(8'h5A);
    p_push(8'hA5);
    set_mode(3'b010);
    chk("R12 frozen mode ignores strobes", empty, 1);
    chk("R11 svc registered in new mode", svc, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cap17_order();
    t_test16();
    t_reverse();
    t_forward_svc();
    t_frozen();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule